// File: doc/BRIEF.md
# Debug Control Register with Gated Request Synchronizer

This block is a three-bit control register that sits next to a processor core. It shapes the core's debug handshake and interrupt gating. A debug host reaches it through a small register port that carries an address, write data, a read/write flag and an access strobe.

- One stored bit masks the core's interrupt enable.
- A second bit forces the debug acknowledge that the rest of the system sees. This keeps debug visible during system-speed accesses, when the core itself has dropped its acknowledge.
- The third bit forces a debug request into the core.

The forced request does not go straight from the register to the core. It passes through a capture flop that loads only while the test access port reports the Run-Test-Idle state. A debugger can therefore arm the request in several cores while they keep running. Moving every test access port into Run-Test-Idle then releases all of the cores together. The capture flop's output is ORed with the external request pin, and the result drives both the core and an observable output.

Top module: `dbg_ctl_top`

## Requirements
- R1: While rst_ni is low, and after it is released, the register and the capture flop are zero. With no access since reset, core_irq_en_o is high when core_dbgack_i is low, ext_dbgack_o equals core_dbgack_i, and core_dbgreq_o equals ext_dbgreq_i.
- R2: An access with acc_en_i=1, acc_wr_i=1 and acc_addr_i=CTL_ADDR (default 5'h04) loads acc_wdata_i into the register at that clock edge. Field positions: bit 2 is interrupt-off, bit 1 is force-request, bit 0 is force-acknowledge.
- R3: acc_rdata_o equals the register in bits [2:0], with zeros above, in any cycle with acc_en_i=1, acc_wr_i=0 and acc_addr_i=CTL_ADDR. In every other cycle acc_rdata_o is all zero.
- R4: A write to any address other than CTL_ADDR leaves the register unchanged.
- R5: core_irq_en_o is high only when core_dbgack_i is low and register bit 2 is low. This gates both the normal and the fast interrupt.
- R6: ext_dbgack_o is the OR of core_dbgack_i and register bit 0.
- R7: The capture flop loads register bit 1 at every clock edge where tap_state_i equals RTI_CODE (default 4'hC). At every other edge it holds its value.
- R8: core_dbgreq_o is the OR of the capture flop and ext_dbgreq_i.
- R9: A write that sets bit 1 while tap_state_i is not RTI_CODE changes the register at once, but leaves core_dbgreq_o unchanged until an edge with tap_state_i equal to RTI_CODE has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Register address |
| acc_wdata_i | input | CTL_W | Write data |
| acc_rdata_o | output | DATA_W | Read data, combinational |
| tap_state_i | input | TAP_W | Current state code of the test access port |
| ext_dbgreq_i | input | 1 | External debug request |
| core_dbgack_i | input | 1 | Debug acknowledge from the core |
| core_dbgreq_o | output | 1 | Combined debug request to the core |
| ext_dbgack_o | output | 1 | Debug acknowledge seen by the system |
| core_irq_en_o | output | 1 | Interrupt enable to the core |

## Verification
Results arrive at three different times:

- Read data, interrupt enable and external acknowledge are combinational. They are due in the same cycle as the inputs that cause them.
- The register content reaches those outputs one edge after a write.
- A forced request needs two edges in Run-Test-Idle: one to write the register and one to load the capture flop.

The bench drives inputs just after the falling edge and compares every output against its own model a moment later, still before the rising edge. It then advances the model at the rising edge from the inputs it applied. Each comparison therefore lines up with the cycle in which the result is due.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned CTL_W        = 3;
  localparam int unsigned BIT_IRQ_OFF  = 2;
  localparam int unsigned BIT_FORCE_RQ = 1;
  localparam int unsigned BIT_FORCE_AK = 0;
  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 5'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  ctl_t              acc_wdata_i,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CTL_W;

  logic hit, wr_en, rd_en;
  ctl_t ctl_q;

  assign hit   = acc_en_i && (acc_addr_i == CTL_ADDR);
  assign wr_en = hit && acc_wr_i;
  assign rd_en = hit && !acc_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctl_q <= '0;
    else if (wr_en) ctl_q <= acc_wdata_i;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o = rd_en ? {{PAD_W{1'b0}}, ctl_q} : '0;
    end else begin : g_nopad
      assign rdata_o = rd_en ? ctl_q[DATA_W-1:0] : '0;
    end
  endgenerate

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dbg_req_gate.sv
module dbg_req_gate #(
  parameter int unsigned TAP_W = 4,
  parameter logic [TAP_W-1:0] RTI_CODE = 4'hC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] tap_state_i,
  input  logic             d_i,
  output logic             q_o
);
  logic open_w;
  assign open_w = (tap_state_i == RTI_CODE);

  // transparent only in Run-Test-Idle; modelled as enabled flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (open_w) q_o <= d_i;
  end
endmodule

// File: rtl/dbg_sig_mix.sv
module dbg_sig_mix
  import dbg_ctl_pkg::*;
(
  input  ctl_t ctl_i,
  input  logic req_sync_i,
  input  logic ext_dbgreq_i,
  input  logic core_dbgack_i,
  output logic core_dbgreq_o,
  output logic ext_dbgack_o,
  output logic core_irq_en_o
);
  assign core_dbgreq_o = req_sync_i | ext_dbgreq_i;
  assign ext_dbgack_o  = core_dbgack_i | ctl_i[BIT_FORCE_AK];
  assign core_irq_en_o = ~(core_dbgack_i | ctl_i[BIT_IRQ_OFF]);
endmodule

// File: rtl/dbg_ctl_top.sv
module dbg_ctl_top
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAP_W    = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 5'h04,
  parameter logic [TAP_W-1:0]  RTI_CODE = 4'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [CTL_W-1:0]  acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic [TAP_W-1:0]  tap_state_i,
  input  logic              ext_dbgreq_i,
  input  logic              core_dbgack_i,
  output logic              core_dbgreq_o,
  output logic              ext_dbgack_o,
  output logic              core_irq_en_o
);
  ctl_t ctl_q;
  logic sync_q;

  dbg_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_en_i    (acc_en_i),
    .acc_wr_i    (acc_wr_i),
    .acc_addr_i  (acc_addr_i),
    .acc_wdata_i (acc_wdata_i),
    .ctl_o       (ctl_q),
    .rdata_o     (acc_rdata_o)
  );

  dbg_req_gate #(.TAP_W(TAP_W), .RTI_CODE(RTI_CODE)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tap_state_i (tap_state_i),
    .d_i         (ctl_q[BIT_FORCE_RQ]),
    .q_o         (sync_q)
  );

  dbg_sig_mix u_mix (
    .ctl_i         (ctl_q),
    .req_sync_i    (sync_q),
    .ext_dbgreq_i  (ext_dbgreq_i),
    .core_dbgack_i (core_dbgack_i),
    .core_dbgreq_o (core_dbgreq_o),
    .ext_dbgack_o  (ext_dbgack_o),
    .core_irq_en_o (core_irq_en_o)
  );
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAP_W    = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 5'h04,
  parameter logic [TAP_W-1:0]  RTI_CODE = 4'hC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_en_i,
  input logic              acc_wr_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [CTL_W-1:0]  acc_wdata_i,
  input logic [DATA_W-1:0] acc_rdata_o,
  input logic [TAP_W-1:0]  tap_state_i,
  input logic              ext_dbgreq_i,
  input logic              core_dbgack_i,
  input logic              core_dbgreq_o,
  input logic              ext_dbgack_o,
  input logic              core_irq_en_o,
  input logic [CTL_W-1:0]  ctl_q,
  input logic              sync_q
);
  logic wr_hit, rd_hit, in_rti;
  assign wr_hit = acc_en_i && acc_wr_i && (acc_addr_i == CTL_ADDR);
  assign rd_hit = acc_en_i && !acc_wr_i && (acc_addr_i == CTL_ADDR);
  assign in_rti = (tap_state_i == RTI_CODE);

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ctl_q == $past(acc_wdata_i));

  p_rdata_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> acc_rdata_o == '0);

  p_no_stray_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(ctl_q));

  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_dbgack_i || ctl_q[BIT_IRQ_OFF]) |-> !core_irq_en_o);

  p_ack_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[BIT_FORCE_AK] |-> ext_dbgack_o);

  p_sync_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rti |=> $stable(sync_q));

  p_sync_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rti |=> sync_q == $past(ctl_q[BIT_FORCE_RQ]));

  p_req_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_dbgreq_i |-> core_dbgreq_o);
endmodule

bind dbg_ctl_top dbg_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_W(TAP_W),
  .CTL_ADDR(CTL_ADDR), .RTI_CODE(RTI_CODE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_en_i      (acc_en_i),
  .acc_wr_i      (acc_wr_i),
  .acc_addr_i    (acc_addr_i),
  .acc_wdata_i   (acc_wdata_i),
  .acc_rdata_o   (acc_rdata_o),
  .tap_state_i   (tap_state_i),
  .ext_dbgreq_i  (ext_dbgreq_i),
  .core_dbgack_i (core_dbgack_i),
  .core_dbgreq_o (core_dbgreq_o),
  .ext_dbgack_o  (ext_dbgack_o),
  .core_irq_en_o (core_irq_en_o),
  .ctl_q         (ctl_q),
  .sync_q        (sync_q)
);

// File: tb/tb_dbg_ctl_top.sv
`timescale 1ns/1ps
module tb_dbg_ctl_top;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAP_W  = 4;
  localparam int unsigned CW     = 3;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 5'h04;
  localparam logic [TAP_W-1:0]  RTI      = 4'hC;
  localparam logic [TAP_W-1:0]  SHIFT_DR = 4'h2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              acc_en = 1'b0, acc_wr = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [CW-1:0]     acc_wdata = '0;
  logic [DATA_W-1:0] acc_rdata;
  logic [TAP_W-1:0]  tap = SHIFT_DR;
  logic              ext_req = 1'b0, core_ack = 1'b0;
  logic              dbgreq, dbgack, irq_en;

  int n_vec = 0;
  int n_bad = 0;
  int m_ctl = 0;
  int m_sync = 0;

  always #2.5 clk = ~clk;

  dbg_ctl_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .tap_state_i(tap), .ext_dbgreq_i(ext_req), .core_dbgack_i(core_ack),
    .core_dbgreq_o(dbgreq), .ext_dbgack_o(dbgack), .core_irq_en_o(irq_en)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    longint exp_rd;
    exp_rd = (acc_en && !acc_wr && acc_addr == CTL_ADDR) ? longint'(m_ctl) : 0;
    chk("R3 rdata", longint'(acc_rdata), exp_rd);
    chk("R5 irq_en", longint'(irq_en), longint'(!(core_ack || m_ctl[2])));
    chk("R6 dbgack", longint'(dbgack), longint'(core_ack || m_ctl[0]));
    chk("R8 dbgreq", longint'(dbgreq), longint'((m_sync != 0) || ext_req));
  endtask

  // drive after falling edge, compare, then advance model at rising edge
  task automatic step(input logic en, input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [CW-1:0] wd, input logic [TAP_W-1:0] ts,
                      input logic er, input logic ca);
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = a; acc_wdata = wd;
    tap = ts; ext_req = er; core_ack = ca;
    #1;
    cmp_all();
    @(posedge clk);
    if (tap == RTI) m_sync = m_ctl[1];
    if (acc_en && acc_wr && acc_addr == CTL_ADDR) m_ctl = int'(acc_wdata);
  endtask

  task automatic rd_check(input string req, input int exp);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = CTL_ADDR;
    #1;
    chk(req, longint'(acc_rdata), longint'(exp));
    acc_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 irq_en in reset", longint'(irq_en), 1);
    chk("R1 dbgreq in reset", longint'(dbgreq), 0);
    chk("R1 dbgack in reset", longint'(dbgack), 0);
    rst_ni = 1'b1;
    rd_check("R1 reg after reset", 0);

    // R2/R3: write then read
    step(1, 1, CTL_ADDR, 3'b101, SHIFT_DR, 0, 0);
    rd_check("R2 write loads", 5);
    step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    // R4: other addresses ignored
    step(1, 1, 5'h05, 3'b010, SHIFT_DR, 0, 0);
    step(1, 1, 5'h00, 3'b000, SHIFT_DR, 0, 0);
    rd_check("R4 other addr no effect", 5);
    // R5/R6 with core ack both ways
    step(0, 0, '0, '0, SHIFT_DR, 0, 1);
    step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    step(1, 1, CTL_ADDR, 3'b000, SHIFT_DR, 0, 0);
    step(0, 0, '0, '0, SHIFT_DR, 0, 1);
    step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    chk("R5 irq permitted", longint'(irq_en), 1);

    // R9: arm outside RTI, no request yet
    step(1, 1, CTL_ADDR, 3'b010, SHIFT_DR, 0, 0);
    repeat (4) step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    chk("R9 armed not released", longint'(dbgreq), 0);
    // R7: one RTI edge releases
    step(0, 0, '0, '0, RTI, 0, 0);
    @(negedge clk); #1;
    chk("R7 released after RTI edge", longint'(dbgreq), 1);
    // R7 hold: clear outside RTI, request persists
    step(1, 1, CTL_ADDR, 3'b000, SHIFT_DR, 0, 0);
    repeat (3) step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    chk("R7 held outside RTI", longint'(dbgreq), 1);
    step(0, 0, '0, '0, RTI, 0, 0);
    step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    chk("R7 cleared after RTI edge", longint'(dbgreq), 0);
    // R8 external request
    step(0, 0, '0, '0, SHIFT_DR, 1, 0);
    // R9: write in RTI takes two edges
    step(1, 1, CTL_ADDR, 3'b010, RTI, 0, 0);
    chk("R9 not same edge", longint'(dbgreq), 0);
    step(0, 0, '0, '0, RTI, 0, 0);
    step(0, 0, '0, '0, SHIFT_DR, 0, 0);
    chk("R9 after second RTI edge", longint'(dbgreq), 1);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom_range(0, 2) == 0) ? ADDR_W'($urandom) : CTL_ADDR;
      step(1'($urandom), 1'($urandom), a, CW'($urandom),
           ($urandom_range(0, 3) == 0) ? RTI : TAP_W'($urandom_range(0, 11)),
           ($urandom_range(0, 4) == 0), 1'($urandom));
    end

    // R1: async reset mid-run clears everything
    @(negedge clk);
    acc_en = 1'b0; ext_req = 1'b0; core_ack = 1'b0;
    rst_ni = 1'b0; m_ctl = 0; m_sync = 0;
    #1;
    chk("R1 reset clears dbgreq", longint'(dbgreq), 0);
    chk("R1 reset clears dbgack", longint'(dbgack), 0);
    chk("R1 reset irq_en", longint'(irq_en), 1);
    @(negedge clk); rst_ni = 1'b1;
    rd_check("R1 reg cleared", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule